// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Scheduler

This block owns refresh timing for an asynchronous DRAM that sits behind an access sequencer. After reset it waits out a long power-up pause with every strobe inactive. It then asks the access arbiter for the bus and runs a fixed number of CAS-before-RAS refresh cycles. Once that burst is complete it raises an init-done flag, and from then on normal traffic may use the memory.

After initialization a free-running interval timer adds one owed refresh per interval. Owed refreshes are counted in a small saturating counter. The block keeps its request raised while any refresh is owed. When the arbiter grants the bus, the block drives the RAS, CAS and WE overrides through one complete CAS-before-RAS cycle. A sticky flag reports when the number of owed refreshes goes above a set limit.

On request the block puts the memory into self refresh. It runs one refresh, then holds CAS and RAS low for at least the minimum self-refresh time. On exit it applies the longer self-refresh precharge, then runs one more refresh before it returns the bus. The interval timer is held cleared while the memory refreshes itself. The row address for each refresh comes from the memory's internal counter, so the block has no address output.

Top module: `dram_refresh_sched`

## Requirements
- R1: After reset release, all outputs stay idle for two synchronizer edges plus PAUSE_CYC cycles: request low, init-done low, bus ownership low, and RAS, CAS and WE high. The request first reads high after clock edge PAUSE_CYC+2 counted from the release. Reset clears the overflow flag.
- R2: After the pause, exactly INIT_CBR refresh cycles are requested. Init-done stays low until the precharge of the last of them ends, and reads high in the first idle cycle after it.
- R3: Every refresh cycle drives the outputs {bus_own, ras_n, cas_n, we_n, self_rfsh} in three phases. First comes 1_1_0_1_0 (CAS low ahead of RAS) for T_CSR cycles. Next comes 1_0_0_1_0 for T_RAS cycles. Last comes the precharge 1_1_1_1_0 for T_RP cycles. The idle pattern is 0_1_1_1_0, and WE stays high throughout.
- R4: A refresh or self-refresh sequence starts only at a clock edge where the request and the grant are both high. While the grant stays low the request is held and the bus is not taken. The request is low whenever the bus is owned.
- R5: Once init-done is high, one refresh becomes owed every INTERVAL_CYC cycles. The first is owed INTERVAL_CYC edges after init-done rises. The request stays high while any refresh is owed.
- R6: Each completed refresh serves one owed refresh. If the owed count would exceed PEND_MAX, the overflow flag rises, and it stays high until reset.
- R7: If the self-refresh request is high, init-done is high and nothing is owed, the block raises its request. On grant it runs one full refresh (R3), then drives CAS low with RAS high for T_CSR cycles, then holds RAS and CAS low with self_rfsh high. During initialization the self-refresh request does not change the burst.
- R8: The self-refresh hold (pattern 1_0_0_1_1) lasts the greater of T_SR_MIN cycles and the number of cycles until the self-refresh request is seen low.
- R9: On self-refresh exit, both strobes go high (1_1_1_1_0) for T_RPS cycles. A full refresh cycle (R3) follows without the bus being released, and then the outputs return to idle.
- R10: While in self refresh the interval timer is held cleared and no refresh becomes owed, however long the hold. The next refresh is owed INTERVAL_CYC edges after the long precharge ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gnt_i | input | 1 | Bus grant from the access arbiter |
| sr_req_i | input | 1 | Level request to enter and remain in self refresh |
| rfsh_req_o | output | 1 | Bus request to the arbiter |
| init_done_o | output | 1 | Power-up pause and initialization burst complete |
| bus_own_o | output | 1 | Strobe overrides below are in force |
| ras_n_o | output | 1 | RAS override, active low |
| cas_n_o | output | 1 | CAS override, active low |
| we_n_o | output | 1 | WE override, held high |
| self_rfsh_o | output | 1 | Memory is held in self refresh |
| owed_ovf_o | output | 1 | Sticky flag: owed refreshes exceeded the limit |

## Verification
The bench goes after off-by-one errors in every timed window: the power-up pause, each strobe phase and the first owed refresh after init and after self refresh. A scheduler that is one cycle short there would break the memory's setup or precharge rules. It checks that the eighth refresh, and not the seventh, raises init-done, and that a self-refresh request during the burst cannot cut it short. A design that let the interval timer run during self refresh would raise a request right after a long hold, and the bench catches it. The bench also drops the self-refresh request both early and late, to catch a hold that ends before the minimum or ignores the request. Finally it lets owed refreshes pile past the limit and checks that the flag survives the drain and is cleared only by reset.

// File: rtl/dram_rfsh_pkg.sv
package dram_rfsh_pkg;

  typedef enum logic [2:0] {
    ST_PAUSE,
    ST_IDLE,
    ST_CLEAD,
    ST_RLOW,
    ST_PRECH,
    ST_SRHOLD,
    ST_SRPRE
  } rfsh_st_t;

  function automatic int unsigned imax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/rfsh_tick_timer.sv
module rfsh_tick_timer #(
  parameter int unsigned PERIOD = 1950
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic clr,
  output logic tick
);
  localparam int unsigned TW = (PERIOD > 2) ? $clog2(PERIOD) : 1;
  localparam logic [TW-1:0] LAST = TW'(PERIOD - 1);

  logic [TW-1:0] tmr_q, tmr_d;

  always_comb begin
    tmr_d = tmr_q;
    tick  = 1'b0;
    if (clr) begin
      tmr_d = '0;
    end else if (en) begin
      if (tmr_q == LAST) begin
        tmr_d = '0;
        tick  = 1'b1;
      end else begin
        tmr_d = tmr_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tmr_q <= '0;
    else        tmr_q <= tmr_d;
  end
endmodule

// File: rtl/rfsh_owed_ctr.sv
module rfsh_owed_ctr #(
  parameter int unsigned LIMIT = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inc,
  input  logic dec,
  output logic nonzero,
  output logic ovf
);
  localparam int unsigned PW = $clog2(LIMIT + 2);
  localparam logic [PW-1:0] SAT = PW'(LIMIT + 1);
  localparam logic [PW-1:0] LIM = PW'(LIMIT);

  logic [PW-1:0] cnt_q, cnt_d;
  logic          ovf_q, ovf_d;

  always_comb begin
    cnt_d = cnt_q;
    ovf_d = ovf_q;
    unique case ({inc, dec})
      2'b10: begin
        if (cnt_q == LIM) ovf_d = 1'b1;
        if (cnt_q != SAT) cnt_d = cnt_q + 1'b1;
      end
      2'b01: if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
      2'b11: if (cnt_q == '0) cnt_d = PW'(1);
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
    end
  end

  assign nonzero = (cnt_q != '0);
  assign ovf     = ovf_q;
endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
  import dram_rfsh_pkg::*;
#(
  parameter int unsigned CLK_MHZ      = 125,
  parameter int unsigned PAUSE_CYC    = 200 * CLK_MHZ,
  parameter int unsigned INTERVAL_CYC = (156 * CLK_MHZ) / 10,
  parameter int unsigned INIT_CBR     = 8,
  parameter int unsigned PEND_MAX     = 7,
  parameter int unsigned T_CSR        = 1,
  parameter int unsigned T_RAS        = (70 * CLK_MHZ + 999) / 1000,
  parameter int unsigned T_RP         = (50 * CLK_MHZ + 999) / 1000,
  parameter int unsigned T_RPS        = (130 * CLK_MHZ + 999) / 1000,
  parameter int unsigned T_SR_MIN     = 100 * CLK_MHZ + 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic gnt_i,
  input  logic sr_req_i,
  output logic rfsh_req_o,
  output logic init_done_o,
  output logic bus_own_o,
  output logic ras_n_o,
  output logic cas_n_o,
  output logic we_n_o,
  output logic self_rfsh_o,
  output logic owed_ovf_o
);
  localparam int unsigned CMAX = imax(imax(imax(PAUSE_CYC, T_SR_MIN), imax(T_RPS, T_RAS)),
                                      imax(T_RP, T_CSR));
  localparam int unsigned CW   = $clog2(CMAX + 1);
  localparam int unsigned IW   = $clog2(INIT_CBR + 1);
  localparam logic [CW-1:0] PAUSE_LAST = CW'(PAUSE_CYC - 1);
  localparam logic [CW-1:0] CSR_LAST   = CW'(T_CSR - 1);
  localparam logic [CW-1:0] RAS_LAST   = CW'(T_RAS - 1);
  localparam logic [CW-1:0] RP_LAST    = CW'(T_RP - 1);
  localparam logic [CW-1:0] RPS_LAST   = CW'(T_RPS - 1);
  localparam logic [CW-1:0] SRMIN_LAST = CW'(T_SR_MIN - 1);

  // reset: asynchronous assert, two-stage synchronous release
  logic rs1_q, rs2_q, rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end
  assign rst_i = rs2_q;

  rfsh_st_t      st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [IW-1:0] init_q, init_d;
  logic          sr_next_q, sr_next_d;
  logic          enter_q, enter_d;
  logic          cbr_done, owed_nz, owed_any, init_done, tick, tmr_en, tmr_clr;

  assign init_done = (init_q == '0);
  assign owed_any  = (init_q != '0) || owed_nz;
  assign rfsh_req_o = (st_q == ST_IDLE) && (owed_any || (sr_req_i && init_done));

  always_comb begin
    st_d      = st_q;
    cnt_d     = cnt_q + 1'b1;
    init_d    = init_q;
    sr_next_d = sr_next_q;
    enter_d   = enter_q;
    cbr_done  = 1'b0;
    unique case (st_q)
      ST_PAUSE: if (cnt_q == PAUSE_LAST) begin
        st_d  = ST_IDLE;
        cnt_d = '0;
      end
      ST_IDLE: begin
        cnt_d = '0;
        if (rfsh_req_o && gnt_i) begin
          st_d      = ST_CLEAD;
          sr_next_d = !owed_any;
        end
      end
      ST_CLEAD: if (cnt_q == CSR_LAST) begin
        cnt_d = '0;
        if (enter_q) begin
          st_d    = ST_SRHOLD;
          enter_d = 1'b0;
        end else begin
          st_d = ST_RLOW;
        end
      end
      ST_RLOW: if (cnt_q == RAS_LAST) begin
        cnt_d = '0;
        st_d  = ST_PRECH;
      end
      ST_PRECH: if (cnt_q == RP_LAST) begin
        cnt_d    = '0;
        cbr_done = 1'b1;
        if (sr_next_q) begin
          sr_next_d = 1'b0;
          enter_d   = 1'b1;
          st_d      = ST_CLEAD;
        end else begin
          st_d = ST_IDLE;
        end
      end
      ST_SRHOLD: if (cnt_q >= SRMIN_LAST) begin
        if (!sr_req_i) begin
          cnt_d = '0;
          st_d  = ST_SRPRE;
        end else begin
          cnt_d = cnt_q;
        end
      end
      ST_SRPRE: if (cnt_q == RPS_LAST) begin
        cnt_d = '0;
        st_d  = ST_CLEAD;
      end
      default: begin
        st_d  = ST_PAUSE;
        cnt_d = '0;
      end
    endcase
    if (cbr_done && (init_q != '0)) init_d = init_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      st_q      <= ST_PAUSE;
      cnt_q     <= '0;
      init_q    <= IW'(INIT_CBR);
      sr_next_q <= 1'b0;
      enter_q   <= 1'b0;
    end else begin
      st_q      <= st_d;
      cnt_q     <= cnt_d;
      init_q    <= init_d;
      sr_next_q <= sr_next_d;
      enter_q   <= enter_d;
    end
  end

  assign tmr_clr = (st_q == ST_SRHOLD);
  assign tmr_en  = init_done && (st_q != ST_SRHOLD) && (st_q != ST_SRPRE);

  rfsh_tick_timer #(.PERIOD(INTERVAL_CYC)) u_tmr (
    .clk  (clk),
    .rst_n(rst_i),
    .en   (tmr_en),
    .clr  (tmr_clr),
    .tick (tick)
  );

  rfsh_owed_ctr #(.LIMIT(PEND_MAX)) u_owed (
    .clk    (clk),
    .rst_n  (rst_i),
    .inc    (tick),
    .dec    (cbr_done && (init_q == '0)),
    .nonzero(owed_nz),
    .ovf    (owed_ovf_o)
  );

  assign init_done_o = init_done;
  assign bus_own_o   = (st_q != ST_PAUSE) && (st_q != ST_IDLE);
  assign ras_n_o     = !((st_q == ST_RLOW) || (st_q == ST_SRHOLD));
  assign cas_n_o     = !((st_q == ST_CLEAD) || (st_q == ST_RLOW) || (st_q == ST_SRHOLD));
  assign we_n_o      = 1'b1;
  assign self_rfsh_o = (st_q == ST_SRHOLD);
endmodule

// File: rtl/dram_refresh_sched_chk.sv
module dram_refresh_sched_chk #(
  parameter int unsigned T_SR_MIN = 12501
) (
  input logic clk,
  input logic rst_n,
  input logic gnt_i,
  input logic rfsh_req_o,
  input logic init_done_o,
  input logic bus_own_o,
  input logic ras_n_o,
  input logic cas_n_o,
  input logic self_rfsh_o,
  input logic owed_ovf_o
);
  int unsigned sr_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           sr_run <= 0;
    else if (self_rfsh_o) sr_run <= sr_run + 1;
    else                  sr_run <= 0;
  end

  a_r3_cas_leads_ras: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n_o) |-> (!cas_n_o && $past(!cas_n_o)));

  a_r3_ras_with_cas: assert property (@(posedge clk) disable iff (!rst_n)
    !ras_n_o |-> !cas_n_o);

  a_r4_grant_takes_bus: assert property (@(posedge clk) disable iff (!rst_n)
    (rfsh_req_o && gnt_i) |=> bus_own_o);

  a_r4_no_req_while_owning: assert property (@(posedge clk) disable iff (!rst_n)
    bus_own_o |-> !rfsh_req_o);

  a_r6_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    owed_ovf_o |=> owed_ovf_o);

  a_r7_sr_after_init: assert property (@(posedge clk) disable iff (!rst_n)
    self_rfsh_o |-> (init_done_o && bus_own_o));

  a_r8_sr_min_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(self_rfsh_o) |-> (sr_run >= T_SR_MIN));
endmodule

bind dram_refresh_sched dram_refresh_sched_chk #(.T_SR_MIN(T_SR_MIN)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .gnt_i      (gnt_i),
  .rfsh_req_o (rfsh_req_o),
  .init_done_o(init_done_o),
  .bus_own_o  (bus_own_o),
  .ras_n_o    (ras_n_o),
  .cas_n_o    (cas_n_o),
  .self_rfsh_o(self_rfsh_o),
  .owed_ovf_o (owed_ovf_o)
);

// File: tb/sim_dram_refresh_sched.sv
module sim_dram_refresh_sched;
  localparam int PAUSE = 20, INTV = 60, NINIT = 8, PMAX = 3;
  localparam int CSR = 1, RAS = 3, RP = 2, RPS = 4, SRMIN = 10;
  localparam int CBRLEN = CSR + RAS + RP;

  localparam logic [4:0] P_IDLE  = 5'b0_1_1_1_0;
  localparam logic [4:0] P_CLEAD = 5'b1_1_0_1_0;
  localparam logic [4:0] P_RLOW  = 5'b1_0_0_1_0;
  localparam logic [4:0] P_PRE   = 5'b1_1_1_1_0;
  localparam logic [4:0] P_SR    = 5'b1_0_0_1_1;

  logic clk = 1'b0;
  logic rst_n, gnt, sr_req;
  logic req, idone, own, ras_n, cas_n, we_n, srf, ovf;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  dram_refresh_sched #(
    .PAUSE_CYC(PAUSE), .INTERVAL_CYC(INTV), .INIT_CBR(NINIT), .PEND_MAX(PMAX),
    .T_CSR(CSR), .T_RAS(RAS), .T_RP(RP), .T_RPS(RPS), .T_SR_MIN(SRMIN)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .gnt_i(gnt), .sr_req_i(sr_req),
    .rfsh_req_o(req), .init_done_o(idone), .bus_own_o(own),
    .ras_n_o(ras_n), .cas_n_o(cas_n), .we_n_o(we_n),
    .self_rfsh_o(srf), .owed_ovf_o(ovf)
  );

  function automatic logic [4:0] pat();
    return {own, ras_n, cas_n, we_n, srf};
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic expect_pat(input string tag, input int n, input logic [4:0] p);
    for (int i = 0; i < n; i++) begin
      chk(tag, int'(pat()), int'(p));
      step();
    end
  endtask

  // at a negedge with req high: grant, then one refresh cycle back to idle
  task automatic cbr_seq(input string tag);
    gnt = 1'b1;
    step();
    gnt = 1'b0;
    expect_pat({tag, " R3 cas lead"}, CSR, P_CLEAD);
    expect_pat({tag, " R3 ras low"}, RAS, P_RLOW);
    expect_pat({tag, " R3 precharge"}, RP, P_PRE);
    chk({tag, " R3 idle after"}, int'(pat()), int'(P_IDLE));
  endtask

  task automatic do_reset();
    rst_n = 1'b0; gnt = 1'b0;
    repeat (3) step();
    chk("R1 reset pattern", int'(pat()), int'(P_IDLE));
    chk("R1 reset ovf clear", int'(ovf), 0);
    chk("R1 reset req/init", int'({req, idone}), 0);
    rst_n = 1'b1;
  endtask

  task automatic pause_and_init();
    int n = 0;
    int quiet = 1;
    while (!req && n < 1000) begin
      step();
      n++;
      if (!req && (pat() != P_IDLE || idone)) quiet = 0;
    end
    chk("R1 pause length", n, PAUSE + 2);
    chk("R1 quiet during pause", quiet, 1);
    for (int k = 0; k < NINIT; k++) begin
      chk("R2 init req", int'(req), 1);
      chk("R2 init_done low", int'(idone), 0);
      cbr_seq("R2 init");
      chk("R7 no self refresh in init", int'(srf), 0);
    end
    chk("R2 init_done high", int'(idone), 1);
  endtask

  // self-refresh visit; drop = sr_active cycle at which sr_req drops
  task automatic sr_cycle(input int drop);
    int n = 0;
    int bad = 0;
    sr_req = 1'b1;
    #1;
    chk("R7 sr request", int'(req), 1);
    gnt = 1'b1;
    step();
    gnt = 1'b0;
    expect_pat("R7 pre cas lead", CSR, P_CLEAD);
    expect_pat("R7 pre ras low", RAS, P_RLOW);
    expect_pat("R7 pre precharge", RP, P_PRE);
    expect_pat("R7 sr cas lead", CSR, P_CLEAD);
    while (srf && n < 1000) begin
      n++;
      if (pat() != P_SR) bad++;
      if (n == drop) sr_req = 1'b0;
      step();
    end
    chk("R8 sr hold pattern", bad, 0);
    chk("R8 sr hold length", n, (drop > SRMIN) ? drop : SRMIN);
    expect_pat("R9 long precharge", RPS, P_PRE);
    expect_pat("R9 post cas lead", CSR, P_CLEAD);
    expect_pat("R9 post ras low", RAS, P_RLOW);
    expect_pat("R9 post precharge", RP, P_PRE);
    chk("R9 idle after exit", int'(pat()), int'(P_IDLE));
    chk("R10 nothing owed on exit", int'(req), 0);
    bad = 0;
    for (int i = 0; i < INTV - CBRLEN - 1; i++) begin
      step();
      if (req) bad++;
    end
    chk("R10 timer restarted", bad, 0);
    step();
    chk("R10 first owed after exit", int'(req), 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog (R1-related hang): cycles=100000 expected fewer");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int bad;
    sr_req = 1'b0;
    do_reset();
    pause_and_init();

    // R5: first owed refresh INTV edges after init_done
    bad = 0;
    for (int i = 0; i < INTV - 1; i++) begin
      step();
      if (req) bad++;
    end
    chk("R5 no early request", bad, 0);
    step();
    chk("R5 first owed", int'(req), 1);

    // R4: without grant nothing moves
    bad = 0;
    for (int i = 0; i < 5; i++) begin
      step();
      if (own || !req) bad++;
    end
    chk("R4 hold without grant", bad, 0);

    // R6: pile up owed refreshes past the limit
    for (int i = 0; i < 3 * INTV - 6; i++) step();
    chk("R6 no overflow at limit", int'(ovf), 0);
    step();
    chk("R6 overflow raised", int'(ovf), 1);
    chk("R5 request while owed", int'(req), 1);
    for (int k = 0; k < PMAX + 1; k++) cbr_seq("R6 drain");
    chk("R6 drained", int'(req), 0);
    chk("R6 overflow sticky", int'(ovf), 1);

    // second run: sr request held during init, then self refresh
    sr_req = 1'b1;
    do_reset();
    pause_and_init();
    sr_cycle(1);
    cbr_seq("R5 serve owed");
    chk("R5 served", int'(req), 0);
    sr_cycle(2 * INTV + 10);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule